// File: doc/BRIEF.md
# Command/response ring pointer controller

This block is the register-side controller of a DMA command engine that shares two circular queues with host software. One queue carries request descriptors and the other carries completion records. Each queue has 32 entries. The block holds the producer and consumer indices of both queues, a base-address word for each index register, and the engine command bits: enable, disable, channel reset and freeze. It also holds an interrupt cause register, an interrupt mask register and an I/O timeout register.

Software submits a descriptor by advancing the request in-index. While the engine is enabled, the block sees that the two request indices differ. It models the engine taking one entry after a fixed latency, then advances the request out-index and the response in-index together and posts a completion cause bit for its port. Software drains completions by advancing the response out-index. It acknowledges causes by writing the cause register back with the bits it has handled set to 0.

Registers are word-addressed on a 3-bit address: 0 command, 1 request in, 2 request out, 3 response in, 4 response out, 5 cause, 6 mask, 7 timeout. Writes take effect at the clock edge where `reg_wr` is high. Reads are combinational.

Top module: `cmdq_ring_ctrl`

## Requirements
- R1: After `rst_n` is low, every register reads 0 except the timeout register, which reads 0x000000FA.
- R2: A write to the request in-register (address 1) stores bits [31:10] as base and bits [9:5] as the index, and bits [4:0] read 0. A write to the response out-register (address 4) stores bits [31:8] as base and bits [7:3] as the index, and bits [2:0] read 0.
- R3: A write to the request out-register (address 2) or the response in-register (address 3) updates only its base bits ([31:10] and [31:8] respectively). The engine-owned index field ([9:5] and [7:3]) keeps its value.
- R4: The engine takes an entry when all of these hold: enable is set, freeze is clear, channel reset is clear, the request indices differ, and the response ring is not full. It starts on the edge after that condition appears. LAT edges later (default 4) it advances the request out-index and the response in-index by one, modulo 32, so index 31 wraps to 0. Entries are taken one at a time.
- R5: In the cause register (address 5), every completion sets bit PORT_SEL. A completion that leaves the request indices equal also sets bit PORT_SEL+8. A write clears each of these bits that is written as 0 and leaves any bit written as 1 unchanged. A completion on the same edge wins over the clear. All other cause bits read 0.
- R6: In the command register (address 0), writing bit 0 as 1 sets enable. Writing bit 1 as 1 clears enable even if bit 0 is also 1, and bit 1 always reads 0. A disable aborts an entry in progress with no index change, and that entry is taken again once the engine is re-enabled.
- R7: Channel reset (command bit 2) holds the value written. While it is set, or on the edge it is written as 1, enable is cleared, the four indices become 0 and no entry is taken. Base bits are kept.
- R8: Freeze (command bit 4) holds the value written. While it is set, no new entry starts.
- R9: The engine does not start an entry while the response in-index plus 1 (modulo 32) equals the response out-index.
- R10: `rsp_pending` is high exactly while the response in-index and out-index differ. `irq` is the OR of the cause bits ANDed with the mask register (address 6).
- R11: The timeout register (address 7) stores bits [15:0] of a write, and its upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| rsp_pending | output | 1 | Response ring holds unconsumed completions |
| irq | output | 1 | Masked completion interrupt |

## Verification
An index register that advances wrongly shows up in the request out or response in readback within LAT+1 cycles of a submission. It also shows as a `rsp_pending` level that stays high after software has caught up. Wrong field packing or a lost base bit shows on the first readback after a write. A wrong stop or reset path shows as an index that moves during the window in which a completion would have landed. A wrong cause update shows on `irq` the edge after the completion.

// File: rtl/cmdq_ring_ctrl.sv
module cmdq_ring_ctrl #(
  parameter int PORT_SEL = 0,
  parameter int LAT      = 4,
  parameter int IDX_W    = 5,
  parameter int TMO_W    = 16,
  parameter logic [TMO_W-1:0] TMO_RST = 16'h00FA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        rsp_pending,
  output logic        irq
);
  localparam int RQ_LSB = 5;
  localparam int RS_LSB = 3;
  localparam int RQ_MSB = RQ_LSB + IDX_W - 1;
  localparam int RS_MSB = RS_LSB + IDX_W - 1;
  localparam int CNT_W  = $clog2(LAT + 1);
  localparam int C_LO   = PORT_SEL;
  localparam int C_HI   = PORT_SEL + 8;
  localparam logic [31:0] RQ_BMSK = ~((32'd1 << (RQ_LSB + IDX_W)) - 32'd1);
  localparam logic [31:0] RS_BMSK = ~((32'd1 << (RS_LSB + IDX_W)) - 32'd1);
  localparam logic [2:0] A_CMD = 3'd0, A_RQI = 3'd1, A_RQO = 3'd2, A_RSI = 3'd3,
                         A_RSO = 3'd4, A_CAU = 3'd5, A_MSK = 3'd6, A_TMO = 3'd7;

  logic             en_q, rst_q, frz_q, c_lo_q, c_hi_q;
  logic [IDX_W-1:0] rq_in_q, rq_out_q, rs_in_q, rs_out_q;
  logic [31:0]      rq_in_b, rq_out_b, rs_in_b, rs_out_b, mask_q;
  logic [TMO_W-1:0] tmo_q;
  logic [CNT_W-1:0] cnt_q;

  wire w_cmd = reg_wr && reg_addr == A_CMD;
  wire w_cau = reg_wr && reg_addr == A_CAU;
  wire dis_w = w_cmd && reg_wdata[1];
  wire rst_now = rst_q || (w_cmd && reg_wdata[2]);
  wire halt = rst_now || dis_w;
  wire [IDX_W-1:0] rq_out_nx = rq_out_q + IDX_W'(1);
  wire [IDX_W-1:0] rs_in_nx  = rs_in_q + IDX_W'(1);
  wire rs_full = rs_in_nx == rs_out_q;
  wire start = en_q && !frz_q && !halt && (rq_in_q != rq_out_q) && !rs_full && cnt_q == '0;
  wire done  = !halt && cnt_q == CNT_W'(1);

  assign rsp_pending = rs_in_q != rs_out_q;
  assign irq = |(((32'(c_lo_q) << C_LO) | (32'(c_hi_q) << C_HI)) & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; rst_q <= 1'b0; frz_q <= 1'b0;
      c_lo_q <= 1'b0; c_hi_q <= 1'b0;
      rq_in_q <= '0; rq_out_q <= '0; rs_in_q <= '0; rs_out_q <= '0;
      rq_in_b <= '0; rq_out_b <= '0; rs_in_b <= '0; rs_out_b <= '0;
      mask_q <= '0; tmo_q <= TMO_RST; cnt_q <= '0;
    end else begin
      if (halt) en_q <= 1'b0;
      else if (w_cmd && reg_wdata[0]) en_q <= 1'b1;
      if (w_cmd) begin
        rst_q <= reg_wdata[2];
        frz_q <= reg_wdata[4];
      end

      if (halt || done) cnt_q <= '0;
      else if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
      else if (start) cnt_q <= CNT_W'(LAT);

      if (rst_now) begin
        rq_in_q <= '0; rq_out_q <= '0; rs_in_q <= '0; rs_out_q <= '0;
      end else begin
        if (reg_wr && reg_addr == A_RQI) rq_in_q <= reg_wdata[RQ_MSB:RQ_LSB];
        if (reg_wr && reg_addr == A_RSO) rs_out_q <= reg_wdata[RS_MSB:RS_LSB];
        if (done) begin
          rq_out_q <= rq_out_nx;
          rs_in_q  <= rs_in_nx;
        end
      end

      if (reg_wr) begin
        case (reg_addr)
          A_RQI: rq_in_b  <= reg_wdata & RQ_BMSK;
          A_RQO: rq_out_b <= reg_wdata & RQ_BMSK;
          A_RSI: rs_in_b  <= reg_wdata & RS_BMSK;
          A_RSO: rs_out_b <= reg_wdata & RS_BMSK;
          A_MSK: mask_q   <= reg_wdata;
          A_TMO: tmo_q    <= reg_wdata[TMO_W-1:0];
          default: ;
        endcase
      end

      c_lo_q <= done || (c_lo_q && !(w_cau && !reg_wdata[C_LO]));
      c_hi_q <= (done && rq_out_nx == rq_in_q) || (c_hi_q && !(w_cau && !reg_wdata[C_HI]));
    end
  end

  always_comb begin
    case (reg_addr)
      A_CMD: reg_rdata = {27'd0, frz_q, 1'b0, rst_q, 1'b0, en_q};
      A_RQI: reg_rdata = rq_in_b  | (32'(rq_in_q)  << RQ_LSB);
      A_RQO: reg_rdata = rq_out_b | (32'(rq_out_q) << RQ_LSB);
      A_RSI: reg_rdata = rs_in_b  | (32'(rs_in_q)  << RS_LSB);
      A_RSO: reg_rdata = rs_out_b | (32'(rs_out_q) << RS_LSB);
      A_CAU: reg_rdata = (32'(c_lo_q) << C_LO) | (32'(c_hi_q) << C_HI);
      A_MSK: reg_rdata = mask_q;
      default: reg_rdata = 32'(tmo_q);
    endcase
  end
endmodule

module cmdq_ring_chk #(parameter int IDX_W = 5) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             rst_bit,
  input logic             dis_req,
  input logic             cause_lo,
  input logic [IDX_W-1:0] rq_in,
  input logic [IDX_W-1:0] rq_out,
  input logic [IDX_W-1:0] rs_in,
  input logic [IDX_W-1:0] rs_out
);
  // R4
  lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n) rq_out == rs_in);
  // R6
  disable_chk: assert property (@(posedge clk) disable iff (!rst_n) dis_req |=> !en);
  // R7
  chan_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_bit |-> (!en && rq_in == '0 && rq_out == '0 && rs_in == '0 && rs_out == '0));
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_in != $past(rs_in) && !rst_bit) |-> (IDX_W'($past(rs_in) + IDX_W'(1)) != $past(rs_out)));
  // R5
  cause_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_out != $past(rq_out) && !rst_bit) |-> cause_lo);
endmodule

bind cmdq_ring_ctrl cmdq_ring_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .rst_bit(rst_q),
  .dis_req(reg_wr && reg_addr == 3'd0 && reg_wdata[1]),
  .cause_lo(c_lo_q), .rq_in(rq_in_q), .rq_out(rq_out_q),
  .rs_in(rs_in_q), .rs_out(rs_out_q)
);

// File: tb/cmdq_ring_ctrl_tb.sv
module cmdq_ring_ctrl_tb;
  localparam int PS  = 0;
  localparam int LAT = 4;
  localparam logic [31:0] CLO = 32'd1 << PS;
  localparam logic [31:0] CHI = 32'd1 << (PS + 8);

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0, reg_rdata;
  logic rsp_pending, irq;
  int errors = 0, total = 0;

  always #2.5 clk = ~clk;

  cmdq_ring_ctrl #(.PORT_SEL(PS), .LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rsp_pending(rsp_pending), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] fq(input logic [31:0] v); return (v >> 5) & 32'd31; endfunction
  function automatic logic [31:0] fs(input logic [31:0] v); return (v >> 3) & 32'd31; endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++; total++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n, m;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk($sformatf("R1 reset addr %0d", a), v, (a == 7) ? 32'h000000FA : 32'h0);
    end
    chk("R1 irq", 32'(irq), 0);
    chk("R1 pending", 32'(rsp_pending), 0);

    wr(3'd1, 32'hABCDE7FF); rd(3'd1, v); chk("R2 req in pack", v, 32'hABCDE7E0);
    wr(3'd4, 32'h123456FF); rd(3'd4, v); chk("R2 rsp out pack", v, 32'h123456F8);
    wr(3'd2, 32'hFFFFFFFF); rd(3'd2, v); chk("R3 req out base only", v, 32'hFFFFFC00);
    wr(3'd3, 32'hFFFFFFFF); rd(3'd3, v); chk("R3 rsp in base only", v, 32'hFFFFFF00);
    chk("R10 pending rs_in!=rs_out", 32'(rsp_pending), 1);

    wr(3'd0, 32'h4); rd(3'd0, v); chk("R7 reset bit reads", v, 32'h4);
    rd(3'd1, v); chk("R7 req in index cleared", v, 32'hABCDE400);
    rd(3'd4, v); chk("R7 rsp out index cleared", v, 32'h12345600);
    wr(3'd1, 32'h20); rd(3'd1, v); chk("R7 index held under reset", fq(v), 0);
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h0); wr(3'd4, 32'h0);

    wr(3'd0, 32'h1); rd(3'd0, v); chk("R6 enable set", v, 32'h1);
    wr(3'd1, 32'h20);
    cyc(LAT);
    rd(3'd2, v); chk("R4 not before latency", fq(v), 0);
    cyc(1);
    rd(3'd2, v); chk("R4 req out after latency", fq(v), 1);
    rd(3'd3, v); chk("R4 rsp in after latency", fs(v), 1);
    chk("R10 pending after completion", 32'(rsp_pending), 1);
    rd(3'd5, v); chk("R5 both cause bits", v, CLO | CHI);
    chk("R10 irq masked", 32'(irq), 0);
    wr(3'd6, CLO); chk("R10 irq unmasked", 32'(irq), 1);
    wr(3'd5, CHI); rd(3'd5, v); chk("R5 clear low bit", v, CHI);
    chk("R10 irq after clear", 32'(irq), 0);
    wr(3'd5, 32'hFFFFFFFF); rd(3'd5, v); chk("R5 write ones no effect", v, CHI);
    wr(3'd5, 32'h0); rd(3'd5, v); chk("R5 clear all", v, 0);
    wr(3'd4, 32'd1 << 3); chk("R10 pending drained", 32'(rsp_pending), 0);

    n = 1;
    for (int i = 0; i < 40; i++) begin
      n = (n + 1) % 32;
      wr(3'd1, 32'hFEDCB800 | (32'(n) << 5));
      cyc(LAT + 2);
      rd(3'd2, v); chk($sformatf("R4 sweep req out %0d", i), fq(v), 32'(n));
      rd(3'd3, v); chk($sformatf("R4 sweep rsp in %0d", i), fs(v), 32'(n));
      rd(3'd1, v); chk($sformatf("R2 sweep req in %0d", i), v, 32'hFEDCB800 | (32'(n) << 5));
      wr(3'd4, 32'(n) << 3);
      chk($sformatf("R10 sweep pending %0d", i), 32'(rsp_pending), 0);
    end

    wr(3'd2, 32'h0); rd(3'd2, v); chk("R3 req out index kept", fq(v), 32'(n));
    wr(3'd3, 32'h0); rd(3'd3, v); chk("R3 rsp in index kept", fs(v), 32'(n));

    wr(3'd5, 32'h0);
    wr(3'd1, 32'((n + 3) % 32) << 5);
    cyc(LAT + 1);
    rd(3'd5, v); chk("R5 low only while not empty", v, CLO);
    cyc(3 * (LAT + 1) + 2);
    rd(3'd2, v); chk("R4 batch drained", fq(v), 32'((n + 3) % 32));
    rd(3'd5, v); chk("R5 empty bit after batch", v, CLO | CHI);
    n = (n + 3) % 32;
    wr(3'd4, 32'(n) << 3);

    m = n;
    wr(3'd4, 32'((m + 6) % 32) << 3);
    wr(3'd1, 32'((m + 20) % 32) << 5);
    cyc(25 * (LAT + 1));
    rd(3'd2, v); chk("R9 stop at full", fq(v), 32'((m + 5) % 32));
    wr(3'd4, 32'((m + 12) % 32) << 3);
    cyc(10 * (LAT + 1));
    rd(3'd3, v); chk("R9 resume to full", fs(v), 32'((m + 11) % 32));
    wr(3'd4, 32'((m + 11) % 32) << 3);
    cyc(12 * (LAT + 1));
    rd(3'd2, v); chk("R9 all taken", fq(v), 32'((m + 20) % 32));
    n = (m + 20) % 32;
    wr(3'd4, 32'(n) << 3);

    wr(3'd0, 32'h11); rd(3'd0, v); chk("R8 freeze reads", v, 32'h11);
    wr(3'd1, 32'((n + 1) % 32) << 5);
    cyc(LAT + 5);
    rd(3'd2, v); chk("R8 frozen no advance", fq(v), 32'(n));
    wr(3'd0, 32'h1);
    cyc(LAT + 2);
    n = (n + 1) % 32;
    rd(3'd2, v); chk("R8 after unfreeze", fq(v), 32'(n));
    wr(3'd4, 32'(n) << 3);

    wr(3'd1, 32'((n + 1) % 32) << 5);
    cyc(2);
    wr(3'd0, 32'h2);
    cyc(LAT + 5);
    rd(3'd2, v); chk("R6 disable aborts", fq(v), 32'(n));
    rd(3'd0, v); chk("R6 enable low after disable", v, 32'h0);
    wr(3'd0, 32'h1);
    cyc(LAT + 2);
    n = (n + 1) % 32;
    rd(3'd2, v); chk("R6 retaken after enable", fq(v), 32'(n));
    wr(3'd4, 32'(n) << 3);
    wr(3'd0, 32'h3); rd(3'd0, v); chk("R6 disable wins over enable", v, 32'h0);

    wr(3'd0, 32'h1);
    wr(3'd1, 32'((n + 1) % 32) << 5);
    cyc(2);
    wr(3'd0, 32'h5); rd(3'd0, v); chk("R7 reset wins over enable", v, 32'h4);
    cyc(LAT + 3);
    wr(3'd0, 32'h0); rd(3'd0, v); chk("R7 reset released", v, 32'h0);
    rd(3'd1, v); chk("R7 req in zero", fq(v), 0);
    rd(3'd2, v); chk("R7 req out zero", fq(v), 0);
    rd(3'd3, v); chk("R7 rsp in zero", fs(v), 0);
    rd(3'd4, v); chk("R7 rsp out zero", fs(v), 0);
    wr(3'd0, 32'h1);
    wr(3'd1, 32'd1 << 5);
    cyc(LAT + 2);
    rd(3'd2, v); chk("R7 restart from zero", fq(v), 1);

    wr(3'd7, 32'h1234); rd(3'd7, v); chk("R11 timeout write", v, 32'h1234);
    wr(3'd7, 32'hABCD5678); rd(3'd7, v); chk("R11 timeout width", v, 32'h5678);

    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule